// File: doc/BRIEF.md
# Program/Erase Completion Status Reader

This unit sits on the read path of a flash device and tells the host when an internally timed program or erase has finished. A one-cycle start pulse launches an operation. The operation is either a word program, which carries the word just loaded, or an erase. From then on an internal down-counter holds the unit busy for a fixed number of clock cycles, and each duration is set by a parameter. While the unit is busy, a selected read does not return array contents. It returns a status word with two completion indicators. The first is a polarity bit: the inverse of the loaded word's bit 7 during a program, or 0 during an erase. The second is a bit 6 that flips once per read access.

A read access is a falling edge of either active-low select, chip enable or output enable, as sampled on the clock. When the counter expires, bit 6 stops moving and reads return array data unchanged. The output-enable flag stands for the tri-state control of the data pins. It is high only when both selects are low. The busy flag is also exported so that the command logic can refuse new commands.

Top module: `pe_status_read`

## Requirements
- R1: After reset the unit is idle (busy low), and the toggle bit holds the parameter value TOGGLE_INIT until a read access occurs during an operation.
- R2: rd_drive is high exactly when ce_n and oe_n are both low; whenever rd_drive is low, rd_data is all zeros.
- R3: When idle and driving, rd_data equals arr_rdata.
- R4: A start_prog pulse accepted while idle sets busy from the next clock edge for exactly PROG_CYCLES cycles.
- R5: A start_erase pulse accepted while idle keeps busy for exactly ERASE_CYCLES cycles; if both starts are high in the same cycle, the erase is taken.
- R6: During a program, a driven read returns in bit 7 the complement of bit 7 of the word loaded with the start.
- R7: During an erase, a driven read returns 0 in bit 7.
- R8: While busy, bit 6 inverts once for each clock cycle in which a falling edge of ce_n or oe_n (or both) is seen; simultaneous falls of both count once.
- R9: Bit 6 never changes while idle, nor while busy in a cycle without a falling select.
- R10: While busy and driving, every bit other than 7 and 6 reads 0.
- R11: Start pulses that arrive while busy are ignored: the duration, the kind and the loaded bit 7 remain those of the running operation.
- R12: Once busy falls, a driven read returns arr_rdata again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | One-cycle request to begin a word program |
| start_erase | input | 1 | One-cycle request to begin an erase |
| load_data | input | DATA_W | Word being programmed, sampled with start_prog |
| ce_n | input | 1 | Active-low chip select, already synchronous to clk |
| oe_n | input | 1 | Active-low output enable, already synchronous to clk |
| arr_rdata | input | DATA_W | Array read data for the current address |
| rd_data | output | DATA_W | Data presented to the pins |
| rd_drive | output | 1 | High when the data pins should be driven |
| busy | output | 1 | Embedded operation in progress |

## Verification
The bench goes after the toggle bit's counting rules. A falling edge on ce_n alone, on oe_n alone, and on both in the same cycle must each cause exactly one inversion. A design that counts the double fall twice would read bit 6 back unchanged. Bit 6 must also stay frozen across reads taken while idle, which is checked by starting an operation with both selects held low. A tracker that counts idle reads would show the wrong starting phase. The bench also fires starts while the unit is busy and fires both starts at once. A design that restarts or switches kind would change bit 7 or lengthen the busy window. Each window is measured to the exact cycle, so an off-by-one counter is caught.

// File: rtl/psr_pkg.sv
package psr_pkg;
   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_t;
endpackage

// File: rtl/psr_op_timer.sv
module psr_op_timer
   import psr_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int POLL_BIT     = 7,
   parameter int PROG_CYCLES  = 500,
   parameter int ERASE_CYCLES = 75000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prog,
   input  logic              start_erase,
   input  logic [DATA_W-1:0] load_data,
   output logic              busy,
   output op_kind_t          kind,
   output logic              poll_val
);
   localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_dur
      $error("operation durations must be at least one cycle");
   end

   logic             busy_q;
   logic [CNT_W-1:0] remain_q;
   op_kind_t         kind_q;
   logic             poll_q;
   logic             accept;

   assign accept = !busy_q && (start_prog || start_erase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         remain_q <= '0;
         kind_q   <= OP_PROG;
         poll_q   <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         if (start_erase) begin
            kind_q   <= OP_ERASE;
            remain_q <= ERASE_LOAD;
            poll_q   <= 1'b0;
         end else begin
            kind_q   <= OP_PROG;
            remain_q <= PROG_LOAD;
            poll_q   <= ~load_data[POLL_BIT];
         end
      end else if (busy_q) begin
         if (remain_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign kind     = kind_q;
   assign poll_val = poll_q;

   assert_idle_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !start_prog && !start_erase |=> !busy_q);
   assert_start_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && (start_prog || start_erase) |=> busy_q);
   assert_erase_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && start_erase |=> kind_q == OP_ERASE);
   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && remain_q != '0 |=> busy_q && $stable(kind_q) && $stable(poll_q)
                                   && remain_q == $past(remain_q) - 1'b1);
endmodule

// File: rtl/psr_access_tracker.sv
module psr_access_tracker #(
   parameter bit TOGGLE_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic busy,
   output logic toggle,
   output logic drive
);
   logic ce_prev_q;
   logic oe_prev_q;
   logic tog_q;
   logic access_fall;

   assign access_fall = (ce_prev_q && !ce_n) || (oe_prev_q && !oe_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_prev_q <= 1'b1;
         oe_prev_q <= 1'b1;
         tog_q     <= TOGGLE_INIT;
      end else begin
         ce_prev_q <= ce_n;
         oe_prev_q <= oe_n;
         if (busy && access_fall) begin
            tog_q <= ~tog_q;
         end
      end
   end

   assign toggle = tog_q;
   assign drive  = !ce_n && !oe_n;

   assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog_q));
   assert_quiet_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !access_fall |=> $stable(tog_q));
   assert_flip_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && access_fall |=> tog_q != $past(tog_q));
endmodule

// File: rtl/psr_read_mux.sv
module psr_read_mux #(
   parameter int DATA_W   = 16,
   parameter int POLL_BIT = 7,
   parameter int TOG_BIT  = 6
) (
   input  logic              busy,
   input  logic              drive,
   input  logic              poll_val,
   input  logic              toggle,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] status_word;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign status_word[i] = poll_val;
      end else if (i == TOG_BIT) begin : g_tog
         assign status_word[i] = toggle;
      end else begin : g_zero
         assign status_word[i] = 1'b0;
      end
      assign rd_data[i] = drive & (busy ? status_word[i] : arr_rdata[i]);
   end
endmodule

// File: rtl/pe_status_read.sv
module pe_status_read
   import psr_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int POLL_BIT     = 7,
   parameter int TOG_BIT      = 6,
   parameter int PROG_CYCLES  = 500,
   parameter int ERASE_CYCLES = 75000,
   parameter bit TOGGLE_INIT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prog,
   input  logic              start_erase,
   input  logic [DATA_W-1:0] load_data,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              busy
);
   localparam logic [DATA_W-1:0] STATUS_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (POLL_BIT >= DATA_W || TOG_BIT >= DATA_W || POLL_BIT == TOG_BIT) begin : g_bad_bits
      $error("status bit positions must be distinct and inside the word");
   end

   logic     busy_w;
   op_kind_t kind_w;
   logic     poll_w;
   logic     tog_w;
   logic     drive_w;

   psr_op_timer #(
      .DATA_W      (DATA_W),
      .POLL_BIT    (POLL_BIT),
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prog (start_prog),
      .start_erase(start_erase),
      .load_data  (load_data),
      .busy       (busy_w),
      .kind       (kind_w),
      .poll_val   (poll_w)
   );

   psr_access_tracker #(
      .TOGGLE_INIT(TOGGLE_INIT)
   ) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .oe_n  (oe_n),
      .busy  (busy_w),
      .toggle(tog_w),
      .drive (drive_w)
   );

   psr_read_mux #(
      .DATA_W  (DATA_W),
      .POLL_BIT(POLL_BIT),
      .TOG_BIT (TOG_BIT)
   ) u_mux (
      .busy     (busy_w),
      .drive    (drive_w),
      .poll_val (poll_w),
      .toggle   (tog_w),
      .arr_rdata(arr_rdata),
      .rd_data  (rd_data)
   );

   assign rd_drive = drive_w;
   assign busy     = busy_w;

   assert_erase_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w && kind_w == OP_ERASE && rd_drive |-> !rd_data[POLL_BIT]);

   always_comb begin
      if (rst_n) begin
         assert_float_zero_R2: assert (rd_drive || rd_data == '0);
         assert_zero_other_R10: assert (!(busy_w && rd_drive) || (rd_data & ~STATUS_MASK) == '0);
      end
   end
endmodule

// File: tb/sim_pe_status_read.sv
module sim_pe_status_read;
   localparam int DW    = 16;
   localparam int PCYC  = 12;
   localparam int ECYC  = 30;
   localparam bit TINIT = 1'b1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_prog = 1'b0;
   logic          start_erase = 1'b0;
   logic [DW-1:0] load_data = '0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [DW-1:0] arr_rdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_drive;
   logic          busy;

   int  checks = 0;
   int  errors = 0;
   int  busy_cycles = 0;
   bit  done = 1'b0;
   logic tog_m;

   always #10 clk = ~clk;

   always @(negedge clk) if (busy) busy_cycles++;

   pe_status_read #(
      .DATA_W(DW), .POLL_BIT(7), .TOG_BIT(6),
      .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC), .TOGGLE_INIT(TINIT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .load_data(load_data), .ce_n(ce_n), .oe_n(oe_n), .arr_rdata(arr_rdata),
      .rd_data(rd_data), .rd_drive(rd_drive), .busy(busy)
   );

   // vector: ce_n, oe_n, arr_rdata, expected drive, expected data
   localparam int NV = 6;
   localparam logic [35:0] VEC [NV] = '{
      {1'b0, 1'b0, 16'hA5C3, 1'b1, 16'hA5C3},
      {1'b1, 1'b0, 16'hFFFF, 1'b0, 16'h0000},
      {1'b0, 1'b1, 16'h1234, 1'b0, 16'h0000},
      {1'b1, 1'b1, 16'h8001, 1'b0, 16'h0000},
      {1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000},
      {1'b0, 1'b0, 16'hFFFF, 1'b1, 16'hFFFF}
   };

   task automatic step();
      @(posedge clk);
      #5;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] stat(input logic b7, input logic b6);
      stat = '0;
      stat[7] = b7;
      stat[6] = b6;
   endfunction

   task automatic read_edge(input bit use_ce, input bit use_oe);
      if (use_ce) ce_n = 1'b1;
      if (use_oe) oe_n = 1'b1;
      step();
      if (use_ce) ce_n = 1'b0;
      if (use_oe) oe_n = 1'b0;
      step();
      tog_m = ~tog_m;
   endtask

   initial begin
      tog_m = TINIT;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      check("R1 busy after reset", 32'(busy), 32'd0);
      check("R2 drive after reset", 32'(rd_drive), 32'd0);

      for (int i = 0; i < NV; i++) begin
         {ce_n, oe_n, arr_rdata} = VEC[i][35:17];
         #1;
         check("R2 drive flag", 32'(rd_drive), 32'(VEC[i][16]));
         check("R3 idle data", 32'(rd_data), 32'(VEC[i][15:0]));
      end

      // idle reads must not move the toggle bit (R9); then start a program
      ce_n = 1'b1; oe_n = 1'b1; step();
      ce_n = 1'b0; oe_n = 1'b0; step();
      oe_n = 1'b1; step();
      oe_n = 1'b0; step();
      load_data = 16'h00A5;
      start_prog = 1'b1;
      busy_cycles = 0;
      step();
      start_prog = 1'b0;
      load_data = 16'h0000;
      check("R4 busy after start", 32'(busy), 32'd1);
      check("R1 R9 R6 first status", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      read_edge(1'b0, 1'b1);
      check("R8 R6 program read", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      for (int g = 0; g < 200 && busy; g++) step();
      check("R4 program length", busy_cycles, PCYC);
      arr_rdata = 16'h1234;
      #1;
      check("R12 data after program", 32'(rd_data), 32'h1234);

      // erase with toggle variants
      read_edge(1'b0, 1'b1);
      tog_m = ~tog_m; // idle read: model takes no flip
      arr_rdata = 16'hFFFF;
      start_erase = 1'b1;
      busy_cycles = 0;
      step();
      start_erase = 1'b0;
      check("R7 R10 erase status", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      read_edge(1'b0, 1'b1);
      check("R8 oe fall", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      read_edge(1'b1, 1'b0);
      check("R8 ce fall", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      read_edge(1'b1, 1'b1);
      check("R8 double fall once", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      step(); step();
      check("R9 no fall holds", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      oe_n = 1'b1;
      step();
      check("R2 busy undriven", 32'({rd_drive, rd_data}), 32'h0);
      oe_n = 1'b0;
      step();
      tog_m = ~tog_m;
      check("R8 after undriven", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      load_data = 16'h0000;
      start_prog = 1'b1;
      step();
      start_prog = 1'b0;
      check("R11 start ignored", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      for (int g = 0; g < 200 && busy; g++) step();
      check("R11 R5 erase length", busy_cycles, ECYC);
      arr_rdata = 16'hBEEF;
      #1;
      check("R12 data after erase", 32'(rd_data), 32'hBEEF);

      // both starts in one cycle
      load_data = 16'h0000;
      start_prog = 1'b1;
      start_erase = 1'b1;
      busy_cycles = 0;
      step();
      start_prog = 1'b0;
      start_erase = 1'b0;
      check("R5 erase wins bit7", 32'(rd_data), 32'(stat(1'b0, tog_m)));
      for (int g = 0; g < 200 && busy; g++) step();
      check("R5 erase wins length", busy_cycles, ECYC);
      done = 1'b1;
   end

   initial begin
      for (int w = 0; w < 100000 && !done; w++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule